// File: doc/BRIEF.md
# Bus Controller Operation Sequencer

This block is the bus-controller front end of a dual-redundant serial avionics data bus interface. A host chooses one of four operations on a two-bit option input and starts it with a falling edge on an active-low strobe. The sequencer then reads command or data words from external host latches. Each word is read as two bytes, high byte first, under an enable output and a byte-select output. It hands each assembled word to the transmitter and marks whether the word needs command/status sync or data sync.

The direction bit of a transmitted command is read inverted on the local side. A command that tells the remote terminal to transmit makes the sequencer collect and count the returned data. A command that tells the terminal to receive makes the sequencer append the requested data words after the command. Received words go back to the host a byte at a time. Each class of word has its own strobe: ordinary data, mode data and status. A monitor input passes every received word to the host regardless of the running operation.

Top module: `bc_op_seq`

## Requirements
- R1: After reset the sequencer is idle (`seq_busy` low), both latch enables are high, `tx_valid` is low, and all three receive strobes and `blk_good` are low.
- R2: An operation starts on a falling edge of `op_stb_n`. `op_sel` is captured at that edge, and later changes to `op_sel` do not alter the running operation.
- R3: A word is fetched as two bytes over two consecutive cycles. The high byte comes first with `fetch_hi`=1, then the low byte with `fetch_hi`=0. `cw_en_n` is low for command words and `dw_en_n` for data words, never both. The fetch begins in the cycle after the strobe edge is seen, and the word `{high,low}` appears on `tx_word` in the cycle after the low byte.
- R4: Command words leave with `tx_cmd_sync`=1 and data words with `tx_cmd_sync`=0. `tx_valid`, `tx_word` and `tx_cmd_sync` hold steady until `tx_ready` is high.
- R5: For `op_sel`=00 with command bit 10 equal to 0, the command is followed by N data words, where N is command bits 4:0 and a value of 0 means 32. The sequencer then waits for one status-sync word and delivers it on `stat_stb`.
- R6: For `op_sel`=00 with command bit 10 equal to 1, the sequencer sends the command and waits for a status-sync word, delivered on `stat_stb`. It then takes N data-sync words, each delivered on `data_stb`, and pulses `blk_good` once after the last one has been delivered.
- R7: `op_sel`=10 sends one command word and stops. `op_sel`=01 sends one data word and stops.
- R8: `op_sel`=11 waits for a data-sync word, delivers it on `mdat_stb` and stops. Status-sync words that arrive while it waits are delivered on `stat_stb`.
- R9: A received word is delivered over two cycles on `host_dout`, high byte first with `deliver_hi`=1, then the low byte. Exactly one receive strobe is high during both cycles.
- R10: While `mon_en` is high, every received word is delivered: status-sync words on `stat_stb`, data-sync words on `mdat_stb`. While `mon_en` is low and the sequencer is idle, received words are not delivered.
- R11: A strobe edge that arrives while `seq_busy` is high is ignored.
- R12: A terminal-to-terminal transfer works as `op_sel`=10 (receive command) followed, after `seq_busy` falls, by `op_sel`=00 (transmit command).
- R13: A status-sync word that arrives during the data phase of R6 is delivered on `stat_stb`. It ends the operation without a `blk_good` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_sel | input | 2 | Operation select, captured at the strobe edge |
| op_stb_n | input | 1 | Active-low start strobe, acts on its falling edge |
| host_din | input | BYTE_W | Byte from the enabled host latch |
| cw_en_n | output | 1 | Command-word latch enable, active low |
| dw_en_n | output | 1 | Data-word latch enable, active low |
| fetch_hi | output | 1 | 1 while the high byte is fetched |
| tx_ready | input | 1 | Transmitter accepts the offered word |
| tx_valid | output | 1 | Word offered to the transmitter |
| tx_word | output | 2*BYTE_W | Word to transmit |
| tx_cmd_sync | output | 1 | 1 = command/status sync, 0 = data sync |
| rx_valid | input | 1 | One-cycle pulse: a validated word was received |
| rx_word | input | 2*BYTE_W | Received word |
| rx_cmd_sync | input | 1 | 1 = received word had command/status sync |
| mon_en | input | 1 | Bus monitor: pass all received traffic |
| host_dout | output | BYTE_W | Delivered byte |
| deliver_hi | output | 1 | 1 while the high byte is delivered |
| data_stb | output | 1 | Strobe for ordinary received data |
| mdat_stb | output | 1 | Strobe for mode data and monitored data |
| stat_stb | output | 1 | Strobe for status and monitored command words |
| blk_good | output | 1 | One-cycle pulse: data block complete |
| seq_busy | output | 1 | High while an operation runs |

## Verification
The assertions check a set of rules on every cycle. Fetch bytes come in order and the two enables never overlap. An offered transmit word stays steady while the transmitter is not ready. Fetching and transmitting happen only while busy. Delivery is a high-then-low pair under one strobe, and `blk_good` follows a completed delivery. Only the bench can show that each operation produces the right number of words in the right order, with the right sync and values. The bench sweeps every word count in both directions and compares against values it computes itself. Capture of `op_sel` at the edge, strobes ignored while busy, monitor routing, and the abort on an early status word are also shown only by the bench scenarios.

// File: rtl/bc_seq_pkg.sv
package bc_seq_pkg;

   typedef enum logic [1:0] {
      CL_DATA = 2'd0,
      CL_MODE = 2'd1,
      CL_STAT = 2'd2
   } rx_class_e;

   localparam logic [1:0] OP_XFER  = 2'b00;
   localparam logic [1:0] OP_DWORD = 2'b01;
   localparam logic [1:0] OP_CWORD = 2'b10;
   localparam logic [1:0] OP_MDATA = 2'b11;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CMD,
      S_DAT,
      S_RXSTAT,
      S_RXDATA,
      S_RXMODE,
      S_GOOD
   } seq_state_e;

endpackage

// File: rtl/bc_stb_edge.sv
module bc_stb_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_n_in,
   output logic fall
);

   logic stb_s;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign stb_s = stb_n_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '1;
            end else begin
               for (int i = SYNC_STAGES - 1; i > 0; i--) begin
                  sync_q[i] <= sync_q[i-1];
               end
               sync_q[0] <= stb_n_in;
            end
         end
         assign stb_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= stb_s;
   end

   assign fall = prev_q & ~stb_s;

endmodule

// File: rtl/bc_word_fetch.sv
module bc_word_fetch #(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic                is_cmd,
   input  logic [BYTE_W-1:0]   host_din,
   input  logic                tx_ready,
   output logic                cw_en_n,
   output logic                dw_en_n,
   output logic                fetch_hi,
   output logic                tx_valid,
   output logic [2*BYTE_W-1:0] tx_word,
   output logic                tx_cmd_sync,
   output logic                done
);

   typedef enum logic [1:0] {F_IDLE, F_HI, F_LO, F_SEND} fetch_st_e;

   fetch_st_e           st_q;
   logic                cmd_q;
   logic [2*BYTE_W-1:0] word_q;
   logic                fetching;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= F_IDLE;
         cmd_q  <= 1'b0;
         word_q <= '0;
      end else begin
         case (st_q)
            F_IDLE: begin
               if (go) begin
                  st_q  <= F_HI;
                  cmd_q <= is_cmd;
               end
            end
            F_HI: begin
               word_q[2*BYTE_W-1:BYTE_W] <= host_din;
               st_q <= F_LO;
            end
            F_LO: begin
               word_q[BYTE_W-1:0] <= host_din;
               st_q <= F_SEND;
            end
            default: begin
               if (tx_ready) begin
                  if (go) begin
                     st_q  <= F_HI;
                     cmd_q <= is_cmd;
                  end else begin
                     st_q <= F_IDLE;
                  end
               end
            end
         endcase
      end
   end

   assign fetching    = (st_q == F_HI) || (st_q == F_LO);
   assign cw_en_n     = !(fetching && cmd_q);
   assign dw_en_n     = !(fetching && !cmd_q);
   assign fetch_hi    = (st_q == F_HI);
   assign tx_valid    = (st_q == F_SEND);
   assign tx_word     = word_q;
   assign tx_cmd_sync = cmd_q;
   assign done        = tx_valid && tx_ready;

endmodule

// File: rtl/bc_rx_router.sv
module bc_rx_router
   import bc_seq_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  rx_class_e           cls_in,
   input  logic [2*BYTE_W-1:0] word_in,
   output logic                busy,
   output logic                deliver_hi,
   output logic [BYTE_W-1:0]   host_dout,
   output logic                data_stb,
   output logic                mdat_stb,
   output logic                stat_stb
);

   typedef enum logic [1:0] {R_IDLE, R_HI, R_LO} route_st_e;

   route_st_e           st_q;
   rx_class_e           cls_q;
   logic [2*BYTE_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= R_IDLE;
         cls_q  <= CL_DATA;
         word_q <= '0;
      end else begin
         case (st_q)
            R_IDLE: begin
               if (take) begin
                  st_q   <= R_HI;
                  cls_q  <= cls_in;
                  word_q <= word_in;
               end
            end
            R_HI:    st_q <= R_LO;
            default: st_q <= R_IDLE;
         endcase
      end
   end

   assign busy       = (st_q != R_IDLE);
   assign deliver_hi = (st_q == R_HI);
   assign host_dout  = deliver_hi ? word_q[2*BYTE_W-1:BYTE_W] : word_q[BYTE_W-1:0];
   assign data_stb   = busy && (cls_q == CL_DATA);
   assign mdat_stb   = busy && (cls_q == CL_MODE);
   assign stat_stb   = busy && (cls_q == CL_STAT);

endmodule

// File: rtl/bc_op_seq.sv
module bc_op_seq
   import bc_seq_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int WC_W        = 5,
   parameter int TR_BIT      = 10,
   parameter int SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          op_sel,
   input  logic                op_stb_n,
   input  logic [BYTE_W-1:0]   host_din,
   output logic                cw_en_n,
   output logic                dw_en_n,
   output logic                fetch_hi,
   input  logic                tx_ready,
   output logic                tx_valid,
   output logic [2*BYTE_W-1:0] tx_word,
   output logic                tx_cmd_sync,
   input  logic                rx_valid,
   input  logic [2*BYTE_W-1:0] rx_word,
   input  logic                rx_cmd_sync,
   input  logic                mon_en,
   output logic [BYTE_W-1:0]   host_dout,
   output logic                deliver_hi,
   output logic                data_stb,
   output logic                mdat_stb,
   output logic                stat_stb,
   output logic                blk_good,
   output logic                seq_busy
);

   localparam int WORD_W    = 2 * BYTE_W;
   localparam int CNT_W     = WC_W + 1;
   localparam int MAX_WORDS = 1 << WC_W;

   generate
      if (TR_BIT >= WORD_W) begin : g_bad_tr
         $error("bc_op_seq: TR_BIT must lie inside the word");
      end
      if (WC_W >= TR_BIT) begin : g_bad_wc
         $error("bc_op_seq: word-count field must sit below TR_BIT");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("bc_op_seq: SYNC_STAGES must not be negative");
      end
   endgenerate

   seq_state_e       st_q, st_d;
   logic [1:0]       op_q, op_d;
   logic             tr_q, tr_d;
   logic [CNT_W-1:0] left_q, left_d;

   logic             fall;
   logic             fetch_go, fetch_is_cmd, fetch_done;
   logic             rt_busy, rt_take, rx_ok, want;
   rx_class_e        rt_cls;
   logic [WC_W-1:0]  wc_field;
   logic [CNT_W-1:0] wc_dec;
   logic             good;

   bc_stb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb_n_in (op_stb_n),
      .fall     (fall)
   );

   bc_word_fetch #(.BYTE_W(BYTE_W)) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (fetch_go),
      .is_cmd      (fetch_is_cmd),
      .host_din    (host_din),
      .tx_ready    (tx_ready),
      .cw_en_n     (cw_en_n),
      .dw_en_n     (dw_en_n),
      .fetch_hi    (fetch_hi),
      .tx_valid    (tx_valid),
      .tx_word     (tx_word),
      .tx_cmd_sync (tx_cmd_sync),
      .done        (fetch_done)
   );

   bc_rx_router #(.BYTE_W(BYTE_W)) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (rt_take),
      .cls_in     (rt_cls),
      .word_in    (rx_word),
      .busy       (rt_busy),
      .deliver_hi (deliver_hi),
      .host_dout  (host_dout),
      .data_stb   (data_stb),
      .mdat_stb   (mdat_stb),
      .stat_stb   (stat_stb)
   );

   assign wc_field = tx_word[WC_W-1:0];
   assign wc_dec   = (wc_field == '0) ? CNT_W'(MAX_WORDS) : {1'b0, wc_field};
   assign rx_ok    = rx_valid && !rt_busy;

   always_comb begin
      st_d         = st_q;
      op_d         = op_q;
      tr_d         = tr_q;
      left_d       = left_q;
      fetch_go     = 1'b0;
      fetch_is_cmd = 1'b0;
      want         = 1'b0;
      rt_cls       = CL_DATA;
      good         = 1'b0;
      case (st_q)
         S_IDLE: begin
            if (fall) begin
               op_d = op_sel;
               case (op_sel)
                  OP_DWORD: begin
                     fetch_go = 1'b1;
                     left_d   = CNT_W'(1);
                     st_d     = S_DAT;
                  end
                  OP_MDATA: st_d = S_RXMODE;
                  default: begin
                     fetch_go     = 1'b1;
                     fetch_is_cmd = 1'b1;
                     st_d         = S_CMD;
                  end
               endcase
            end
         end
         S_CMD: begin
            if (fetch_done) begin
               if (op_q == OP_CWORD) begin
                  st_d = S_IDLE;
               end else begin
                  tr_d   = tx_word[TR_BIT];
                  left_d = wc_dec;
                  if (!tx_word[TR_BIT]) begin
                     fetch_go = 1'b1;
                     st_d     = S_DAT;
                  end else begin
                     st_d = S_RXSTAT;
                  end
               end
            end
         end
         S_DAT: begin
            if (fetch_done) begin
               if (left_q > CNT_W'(1)) begin
                  left_d   = left_q - CNT_W'(1);
                  fetch_go = 1'b1;
               end else if (op_q == OP_DWORD) begin
                  st_d = S_IDLE;
               end else begin
                  st_d = S_RXSTAT;
               end
            end
         end
         S_RXSTAT: begin
            want   = rx_cmd_sync;
            rt_cls = CL_STAT;
            if (rx_ok && rx_cmd_sync) st_d = tr_q ? S_RXDATA : S_IDLE;
         end
         S_RXDATA: begin
            want   = 1'b1;
            rt_cls = rx_cmd_sync ? CL_STAT : CL_DATA;
            if (rx_ok) begin
               if (rx_cmd_sync)                st_d = S_IDLE;
               else if (left_q == CNT_W'(1))   st_d = S_GOOD;
               else                            left_d = left_q - CNT_W'(1);
            end
         end
         S_RXMODE: begin
            want   = 1'b1;
            rt_cls = rx_cmd_sync ? CL_STAT : CL_MODE;
            if (rx_ok && !rx_cmd_sync) st_d = S_IDLE;
         end
         default: begin
            if (!rt_busy) begin
               good = 1'b1;
               st_d = S_IDLE;
            end
         end
      endcase
      if (mon_en) rt_cls = rx_cmd_sync ? CL_STAT : CL_MODE;
   end

   assign rt_take = rx_ok && (want || mon_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         op_q   <= OP_XFER;
         tr_q   <= 1'b0;
         left_q <= '0;
      end else begin
         st_q   <= st_d;
         op_q   <= op_d;
         tr_q   <= tr_d;
         left_q <= left_d;
      end
   end

   assign blk_good = good;
   assign seq_busy = (st_q != S_IDLE);

endmodule

// File: rtl/bc_op_seq_chk.sv
module bc_op_seq_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cw_en_n,
   input logic                dw_en_n,
   input logic                fetch_hi,
   input logic                tx_valid,
   input logic                tx_ready,
   input logic [2*BYTE_W-1:0] tx_word,
   input logic                tx_cmd_sync,
   input logic                deliver_hi,
   input logic                data_stb,
   input logic                mdat_stb,
   input logic                stat_stb,
   input logic                blk_good,
   input logic                seq_busy
);

   logic any_stb;
   assign any_stb = data_stb || mdat_stb || stat_stb;

   p_enable_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!cw_en_n && !dw_en_n));

   p_cw_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cw_en_n && fetch_hi) |=> (!cw_en_n && !fetch_hi));

   p_dw_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dw_en_n && fetch_hi) |=> (!dw_en_n && !fetch_hi));

   p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_word) && $stable(tx_cmd_sync)));

   p_work_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cw_en_n || !dw_en_n || tx_valid) |-> seq_busy);

   p_one_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({data_stb, mdat_stb, stat_stb}));

   p_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (any_stb && deliver_hi) |=> (any_stb && !deliver_hi && $stable({data_stb, mdat_stb, stat_stb})));

   p_good_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
      blk_good |-> ($past(data_stb || mdat_stb) && !$past(deliver_hi) && seq_busy));

endmodule

bind bc_op_seq bc_op_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cw_en_n     (cw_en_n),
   .dw_en_n     (dw_en_n),
   .fetch_hi    (fetch_hi),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .tx_word     (tx_word),
   .tx_cmd_sync (tx_cmd_sync),
   .deliver_hi  (deliver_hi),
   .data_stb    (data_stb),
   .mdat_stb    (mdat_stb),
   .stat_stb    (stat_stb),
   .blk_good    (blk_good),
   .seq_busy    (seq_busy)
);

// File: tb/bc_op_seq_tb_top.sv
`timescale 1ns/1ps
module bc_op_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic        op_stb_n = 1'b1;
   logic [7:0]  host_din;
   logic        cw_en_n, dw_en_n, fetch_hi;
   logic        tx_ready;
   logic        tx_valid;
   logic [15:0] tx_word;
   logic        tx_cmd_sync;
   logic        rx_valid = 1'b0;
   logic [15:0] rx_word = '0;
   logic        rx_cmd_sync = 1'b0;
   logic        mon_en = 1'b0;
   logic [7:0]  host_dout;
   logic        deliver_hi, data_stb, mdat_stb, stat_stb, blk_good, seq_busy;

   always #4 clk = ~clk;

   bc_op_seq dut_i (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .op_stb_n(op_stb_n),
      .host_din(host_din), .cw_en_n(cw_en_n), .dw_en_n(dw_en_n), .fetch_hi(fetch_hi),
      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_word(tx_word), .tx_cmd_sync(tx_cmd_sync),
      .rx_valid(rx_valid), .rx_word(rx_word), .rx_cmd_sync(rx_cmd_sync), .mon_en(mon_en),
      .host_dout(host_dout), .deliver_hi(deliver_hi), .data_stb(data_stb),
      .mdat_stb(mdat_stb), .stat_stb(stat_stb), .blk_good(blk_good), .seq_busy(seq_busy)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // host latches
   logic [15:0] cw_latch = '0;
   int          dw_idx = 0;
   logic [15:0] dw_cur;

   function automatic logic [15:0] dw_val(input int k);
      return 16'(16'h3C00 + k * 273);
   endfunction

   function automatic logic [15:0] rx_val(input int k);
      return 16'h5A00 ^ 16'(k * 515);
   endfunction

   assign dw_cur = dw_val(dw_idx);
   always_comb begin
      if (!cw_en_n)      host_din = fetch_hi ? cw_latch[15:8] : cw_latch[7:0];
      else if (!dw_en_n) host_din = fetch_hi ? dw_cur[15:8] : dw_cur[7:0];
      else               host_din = 8'hEE;
   end

   always @(posedge clk) if (!dw_en_n && !fetch_hi) dw_idx <= dw_idx + 1;

   // transmitter readiness
   logic tx_stall = 1'b0;
   always @(negedge clk) tx_ready <= !tx_stall || (cyc % 3 != 0);

   // logs, sampled after the falling edge
   logic [15:0] tx_w [0:4095];
   logic        tx_s [0:4095];
   logic [15:0] dl_w [0:4095];
   int          dl_c [0:4095];
   int          tx_n = 0, dl_n = 0, good_n = 0;
   logic [7:0]  hi_hold = '0;

   always begin
      @(negedge clk);
      #1;
      if (tx_valid && tx_ready) begin
         tx_w[tx_n] = tx_word;
         tx_s[tx_n] = tx_cmd_sync;
         tx_n++;
      end
      if (data_stb || mdat_stb || stat_stb) begin
         if (deliver_hi) begin
            hi_hold = host_dout;
         end else begin
            dl_w[dl_n] = {hi_hold, host_dout};
            dl_c[dl_n] = stat_stb ? 2 : (mdat_stb ? 1 : 0);
            dl_n++;
         end
      end
      if (blk_good) good_n++;
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog act=%0d exp<150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic [1:0] op);
      @(negedge clk);
      op_sel   = op;
      op_stb_n = 1'b0;
      @(negedge clk);
      op_stb_n = 1'b1;
   endtask

   task automatic rx_send(input logic [15:0] w, input logic cs);
      @(negedge clk);
      rx_valid = 1'b1; rx_word = w; rx_cmd_sync = cs;
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while (seq_busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 3000) chk(1'b0, req, 1, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_tx(input int target, input string req);
      int n = 0;
      while (tx_n < target && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 3000) chk(1'b0, req, tx_n, target);
   endtask

   initial begin
      int t0, d0, g0, b0, nw, bad;
      logic [15:0] cmd;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!seq_busy && cw_en_n && dw_en_n && !tx_valid, "R1 idle/enables", {seq_busy, cw_en_n, dw_en_n, tx_valid}, 4'b0110);
      chk(!data_stb && !mdat_stb && !stat_stb && !blk_good, "R1 strobes", {data_stb, mdat_stb, stat_stb, blk_good}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3/R4 exact fetch timing, lone command (R7)
      cw_latch = 16'hA5C3;
      t0 = tx_n; d0 = dw_idx;
      @(negedge clk);
      op_sel = 2'b10; op_stb_n = 1'b0;
      @(negedge clk);
      chk(!cw_en_n && dw_en_n && fetch_hi, "R3 high byte first", {cw_en_n, dw_en_n, fetch_hi}, 3'b011);
      op_stb_n = 1'b1;
      @(negedge clk);
      chk(!cw_en_n && !fetch_hi, "R3 low byte second", {cw_en_n, fetch_hi}, 2'b00);
      @(negedge clk);
      chk(tx_valid && tx_word == 16'hA5C3 && tx_cmd_sync, "R4 command word with cmd sync", {tx_valid, tx_cmd_sync, tx_word}, {2'b11, 16'hA5C3});
      wait_idle("R7 lone cmd hang");
      chk(tx_n - t0 == 1 && dw_idx == d0, "R7 lone command only", tx_n - t0, 1);

      // R2 + R7: data word option, op_sel changed after the edge
      t0 = tx_n; d0 = dw_idx;
      @(negedge clk);
      op_sel = 2'b01; op_stb_n = 1'b0;
      @(negedge clk);
      op_sel = 2'b10; op_stb_n = 1'b1;
      wait_idle("R2 hang");
      chk(tx_n - t0 == 1 && !tx_s[t0] && tx_w[t0] == dw_val(d0), "R2 R7 data word despite op_sel change", tx_w[t0], dw_val(d0));

      // R5 sweep: receive-command, all word counts, stalls on odd counts (R4)
      for (int wc = 0; wc < 32; wc++) begin
         nw  = (wc == 0) ? 32 : wc;
         cmd = {5'd3, 1'b0, 5'd2, 5'(wc)};
         cw_latch = cmd;
         tx_stall = wc[0];
         t0 = tx_n; d0 = dw_idx; b0 = dl_n;
         strobe(2'b00);
         wait_tx(t0 + nw + 1, "R5 tx count");
         rx_send(16'h1800 + 16'(wc), 1'b1);
         wait_idle("R5 hang");
         chk(tx_n - t0 == nw + 1, "R5 word count", tx_n - t0, nw + 1);
         chk(tx_w[t0] == cmd && tx_s[t0], "R5 R4 command first", tx_w[t0], cmd);
         bad = 0;
         for (int i = 0; i < nw; i++)
            if (tx_w[t0 + 1 + i] != dw_val(d0 + i) || tx_s[t0 + 1 + i]) bad++;
         chk(bad == 0, "R5 R4 data words and sync", bad, 0);
         chk(dl_n - b0 == 1 && dl_c[b0] == 2 && dl_w[b0] == 16'h1800 + 16'(wc), "R5 status delivered", dl_w[b0], 16'h1800 + 16'(wc));
      end
      tx_stall = 1'b0;

      // R6 sweep: transmit-command, all word counts
      for (int wc = 0; wc < 32; wc++) begin
         nw  = (wc == 0) ? 32 : wc;
         cmd = {5'd4, 1'b1, 5'd7, 5'(wc)};
         cw_latch = cmd;
         t0 = tx_n; b0 = dl_n; g0 = good_n;
         strobe(2'b00);
         wait_tx(t0 + 1, "R6 cmd");
         rx_send(16'h2000, 1'b1);
         for (int i = 0; i < nw; i++) rx_send(rx_val(wc + i), 1'b0);
         wait_idle("R6 hang");
         bad = 0;
         for (int i = 0; i < nw; i++)
            if (dl_w[b0 + 1 + i] != rx_val(wc + i) || dl_c[b0 + 1 + i] != 0) bad++;
         chk(tx_n - t0 == 1 && dl_n - b0 == nw + 1 && dl_c[b0] == 2, "R6 counts", dl_n - b0, nw + 1);
         chk(bad == 0, "R6 R9 data delivered hi-first on data strobe", bad, 0);
         chk(good_n - g0 == 1, "R6 one good-block pulse", good_n - g0, 1);
      end

      // R8 mode data
      b0 = dl_n;
      strobe(2'b11);
      rx_send(16'h2A00, 1'b1);
      chk(seq_busy && dl_n - b0 == 1 && dl_c[b0] == 2, "R8 status while waiting", dl_c[b0], 2);
      rx_send(16'h00AB, 1'b0);
      wait_idle("R8 hang");
      chk(dl_n - b0 == 2 && dl_c[b0 + 1] == 1 && dl_w[b0 + 1] == 16'h00AB, "R8 mode data strobe", dl_w[b0 + 1], 16'h00AB);

      // R10 monitor
      b0 = dl_n;
      mon_en = 1'b1;
      rx_send(16'hC0DE, 1'b1);
      rx_send(16'hBEEF, 1'b0);
      chk(dl_n - b0 == 2 && dl_c[b0] == 2 && dl_w[b0] == 16'hC0DE, "R10 R9 monitor status word", dl_w[b0], 16'hC0DE);
      chk(dl_c[b0 + 1] == 1 && dl_w[b0 + 1] == 16'hBEEF, "R10 monitor data word", dl_w[b0 + 1], 16'hBEEF);
      mon_en = 1'b0;
      b0 = dl_n;
      rx_send(16'h1234, 1'b0);
      rx_send(16'h4321, 1'b1);
      chk(dl_n == b0 && !seq_busy, "R10 idle words ignored", dl_n - b0, 0);

      // R11 strobe while busy
      cmd = {5'd3, 1'b0, 5'd2, 5'd3};
      cw_latch = cmd;
      t0 = tx_n;
      strobe(2'b00);
      strobe(2'b01);
      wait_tx(t0 + 4, "R11 tx");
      rx_send(16'h1801, 1'b1);
      wait_idle("R11 hang");
      repeat (6) @(negedge clk);
      chk(tx_n - t0 == 4 && !seq_busy, "R11 extra strobe ignored", tx_n - t0, 4);

      // R12 terminal-to-terminal
      t0 = tx_n; b0 = dl_n; g0 = good_n;
      cw_latch = {5'd5, 1'b0, 5'd1, 5'd2};
      strobe(2'b10);
      wait_idle("R12 first");
      cw_latch = {5'd6, 1'b1, 5'd1, 5'd2};
      strobe(2'b00);
      wait_tx(t0 + 2, "R12 second cmd");
      rx_send(16'h3000, 1'b1);
      rx_send(16'h0101, 1'b0);
      rx_send(16'h0202, 1'b0);
      wait_idle("R12 hang");
      chk(tx_n - t0 == 2 && tx_s[t0] && tx_s[t0 + 1] && tx_w[t0 + 1] == {5'd6, 1'b1, 5'd1, 5'd2},
          "R12 two commands", tx_w[t0 + 1], {5'd6, 1'b1, 5'd1, 5'd2});
      chk(dl_n - b0 == 3 && good_n - g0 == 1, "R12 data and good block", good_n - g0, 1);

      // R13 early status aborts block
      b0 = dl_n; g0 = good_n;
      cw_latch = {5'd4, 1'b1, 5'd7, 5'd4};
      t0 = tx_n;
      strobe(2'b00);
      wait_tx(t0 + 1, "R13 cmd");
      rx_send(16'h2001, 1'b1);
      rx_send(16'h0A0A, 1'b0);
      rx_send(16'h0B0B, 1'b0);
      rx_send(16'h7777, 1'b1);
      wait_idle("R13 hang");
      chk(dl_n - b0 == 4 && dl_c[b0 + 3] == 2 && dl_w[b0 + 3] == 16'h7777, "R13 status delivered", dl_w[b0 + 3], 16'h7777);
      chk(good_n == g0 && !seq_busy, "R13 no good block", good_n - g0, 0);

      summary();
      $finish;
   end

endmodule